// File: doc/BRIEF.md
# Radio SPI Transaction Framer

This block turns one high-level request from a host into a complete SPI session with a short-range radio transceiver. It supports five request kinds. A configuration write sends a 16-bit value. A register read returns two bytes. A command strobe is a single byte. A transmit-FIFO burst writes a host-chosen number of payload bytes. A receive-FIFO burst reads a host-chosen number of bytes. The block builds the header byte, drives the serial clock, the active-low chip select and the serial output, and samples the serial input.

Every session begins with a header byte. While that header shifts out, the radio returns a status byte, and the block hands it back to the host. The block also returns the status byte sent with each transmit-burst payload byte. Bytes received after the header of a read or receive burst are passed to the host one at a time. Transmit payload bytes are pulled from the host through a request/valid handshake. The serial clock stalls low until each byte is offered.

Top module: `radio_spi_framer`

## Requirements
- R1: The first byte of every session is the header {bit7 = 0, bit6 = 1 for register read and receive burst / 0 otherwise, bits 5:0 = address}, and every byte is shifted most-significant bit first.
- R2: Kind 0 (configuration write) sends the header and then req_wdata[15:8] and req_wdata[7:0]. Bits received on spi_so during those two data bytes produce no pulse on rx_valid or status_valid.
- R3: Kind 2 (command strobe, also used for kinds 5 to 7) sends only the header carrying req_addr, including the no-op address 0x00, and then releases chip select.
- R4: The byte received during the header is presented on status with a one-cycle status_valid pulse, for every kind. status_valid and rx_valid are never high together.
- R5: Kind 3 (transmit burst) uses address 0x3E, sends req_len payload bytes taken from tx_byte, and pulses status_valid with the byte received alongside each payload byte.
- R6: Kind 1 (register read, two bytes) and kind 4 (receive burst, address 0x3F, req_len bytes) send 0x00 after the header. Each byte received after the header is presented on rx_byte with a one-cycle rx_valid pulse.
- R7: Chip select stays low from the first header bit until the last byte of the session, with no release between bytes.
- R8: spi_sclk is low whenever chip select is high. Each high phase lasts exactly CLK_DIV clock cycles and each low phase lasts at least CLK_DIV cycles. spi_si changes only while spi_sclk is low, and spi_so is sampled at the rising edge.
- R9: During a transmit burst, tx_req is high while the next payload byte is awaited. Until tx_valid arrives, spi_sclk stays low and chip select stays low.
- R10: done pulses for one cycle in exactly the cycle chip select rises. Chip select then stays high for at least 4*CLK_DIV cycles (two SClk periods) before the next session starts.
- R11: After reset, chip select is high, spi_sclk is low, req_ready is high, and done, tx_req, rx_valid and status_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle and able to accept a request |
| req_kind | input | 3 | 0 write, 1 read, 2 strobe, 3 TX burst, 4 RX burst |
| req_addr | input | 6 | Register or strobe address (kinds 0, 1, 2) |
| req_wdata | input | 16 | Configuration value for kind 0 |
| req_len | input | LEN_W | Burst byte count for kinds 3 and 4 |
| tx_req | output | 1 | Next transmit payload byte wanted |
| tx_valid | input | 1 | tx_byte holds the next payload byte |
| tx_byte | input | 8 | Transmit payload byte |
| rx_valid | output | 1 | One-cycle pulse: rx_byte is new |
| rx_byte | output | 8 | Byte read from the radio |
| status_valid | output | 1 | One-cycle pulse: status is new |
| status | output | 8 | Radio status byte |
| done | output | 1 | One-cycle pulse when the session ends |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_si | output | 1 | Serial data to the radio |
| spi_so | input | 1 | Serial data from the radio |

## Verification
The hardest condition to create is a transmit burst in which the host withholds a payload byte. That leaves the session paused mid-burst, with chip select low and the clock parked. The bench's host agent waits a programmable number of cycles after tx_req before offering each byte. The checks confirm that the clock stays low and chip select stays asserted through the pause, and that the bytes the radio model captures are still exact. Back-to-back requests are issued with no idle time between them, so the chip-select gap is measured at its minimum.

// File: rtl/radio_spi_framer.sv
module radio_spi_framer #(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [5:0]       req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             tx_req,
  input  logic             tx_valid,
  input  logic [7:0]       tx_byte,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic             status_valid,
  output logic [7:0]       status,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_si,
  input  logic             spi_so
);

  localparam int GAP_CYC = 4 * CLK_DIV;
  localparam int CW      = $clog2(GAP_CYC + 1);
  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_TX = 3'd3, K_RX = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_FETCH, S_GAP} state_t;

  state_t           st;
  logic [CW-1:0]    cnt;
  logic [2:0]       bitn;
  logic             hdr;
  logic [2:0]       kind;
  logic [15:0]      wdata;
  logic [LEN_W-1:0] left;
  logic [7:0]       tx_sh, rx_sh;

  wire half_end = (cnt == CW'(CLK_DIV - 1));
  wire gap_end  = (cnt == CW'(GAP_CYC - 1));
  wire req_rd   = (req_kind == K_RD) || (req_kind == K_RX);
  wire [5:0] hdr_addr = (req_kind == K_TX) ? 6'h3E :
                        (req_kind == K_RX) ? 6'h3F : req_addr;
  wire [LEN_W-1:0] first_left =
      (req_kind == K_WR || req_kind == K_RD) ? LEN_W'(2) :
      (req_kind == K_TX || req_kind == K_RX) ? req_len : '0;

  assign req_ready = (st == S_IDLE);
  assign tx_req    = (st == S_FETCH);
  assign spi_si    = !spi_cs_n && tx_sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cnt <= '0;
      bitn <= '0;
      hdr <= 1'b0;
      kind <= '0;
      wdata <= '0;
      left <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte <= '0;
      status_valid <= 1'b0;
      status <= '0;
      done <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      status_valid <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          kind <= req_kind;
          wdata <= req_wdata;
          left <= first_left;
          tx_sh <= {1'b0, req_rd, hdr_addr};
          hdr <= 1'b1;
          bitn <= '0;
          cnt <= '0;
          spi_cs_n <= 1'b0;
          st <= S_LOW;
        end
        S_LOW: if (half_end) begin
          cnt <= '0;
          spi_sclk <= 1'b1;
          rx_sh <= {rx_sh[6:0], spi_so};
          st <= S_HIGH;
        end else cnt <= cnt + 1'b1;
        S_HIGH: if (half_end) begin
          cnt <= '0;
          spi_sclk <= 1'b0;
          bitn <= bitn + 1'b1;
          if (bitn != 3'd7) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            st <= S_LOW;
          end else begin
            hdr <= 1'b0;
            if (hdr || kind == K_TX) begin
              status <= rx_sh;
              status_valid <= 1'b1;
            end else if (kind == K_RD || kind == K_RX) begin
              rx_byte <= rx_sh;
              rx_valid <= 1'b1;
            end
            if (left == '0) begin
              spi_cs_n <= 1'b1;
              done <= 1'b1;
              st <= S_GAP;
            end else begin
              left <= left - 1'b1;
              if (kind == K_TX) st <= S_FETCH;
              else begin
                tx_sh <= (kind != K_WR) ? 8'h00 :
                         (left == LEN_W'(2)) ? wdata[15:8] : wdata[7:0];
                st <= S_LOW;
              end
            end
          end
        end else cnt <= cnt + 1'b1;
        S_FETCH: if (tx_valid) begin
          tx_sh <= tx_byte;
          cnt <= '0;
          st <= S_LOW;
        end
        S_GAP: if (gap_end) begin
          cnt <= '0;
          st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  p_si_steady_r8: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> $stable(spi_si));
  p_stall_parked_r9: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (!spi_sclk && !spi_cs_n));
  p_done_at_release_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(spi_cs_n));
  p_ready_released_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    !(status_valid && rx_valid));
  p_held_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !done && $past(!spi_cs_n)) |-> $past(!req_ready));

endmodule

// File: tb/tb_radio_spi_framer.sv
module tb_radio_spi_framer;
  localparam int CLK_DIV = 3;
  localparam int LEN_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic tx_req;
  logic tx_valid = 1'b0;
  logic [7:0] tx_byte = '0;
  logic rx_valid, status_valid, done;
  logic [7:0] rx_byte, status;
  logic spi_sclk, spi_cs_n, spi_si;
  logic spi_so = 1'b0;

  radio_spi_framer #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .status_valid(status_valid),
    .status(status), .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // radio model
  logic [7:0] reply_q[$];
  logic [7:0] mosi_q[$];
  int kbit = 0, mbits = 0;
  logic [7:0] msh = '0;
  logic prev_sclk_r = 1'b0;

  function automatic logic reply_bit(int k);
    if (k / 8 < reply_q.size()) return reply_q[k/8][7 - (k % 8)];
    return 1'b0;
  endfunction

  initial forever begin
    @(spi_cs_n or spi_sclk);
    if (spi_cs_n !== 1'b0) begin
      kbit = 0;
      mbits = 0;
    end else if (prev_sclk_r && !spi_sclk) begin
      kbit++;
    end else if (!prev_sclk_r && spi_sclk) begin
      msh = {msh[6:0], spi_si};
      mbits++;
      if (mbits == 8) begin
        mosi_q.push_back(msh);
        mbits = 0;
      end
    end
    prev_sclk_r = spi_sclk;
    spi_so = reply_bit(kbit);
  end

  // host transmit agent
  logic [7:0] txq[$];
  int stall_lim = 0, wait_n = 0;
  initial forever begin
    @(negedge clk);
    if (tx_valid) tx_valid = 1'b0;
    else if (tx_req) begin
      if (wait_n >= stall_lim && txq.size() > 0) begin
        tx_byte = txq.pop_front();
        tx_valid = 1'b1;
        wait_n = 0;
      end else wait_n++;
    end
  end

  // per-clock monitor
  logic [7:0] got_st[$], got_rx[$];
  int done_cnt = 0, stall_cyc = 0, hi_run = 0, lo_run = 0, cs_hi_run = 1000;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  bit mon_on = 0;
  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      if (spi_cs_n) chk(!spi_sclk, "R8 sclk low while deselected", spi_sclk, 0);
      if (tx_req) begin
        chk(!spi_sclk && !spi_cs_n, "R9 parked during stall", {spi_sclk, spi_cs_n}, 0);
        stall_cyc++;
      end
      if (done || (spi_cs_n && !prev_cs))
        chk(done == (spi_cs_n && !prev_cs), "R10 done with release", done, 1);
      if (spi_sclk) hi_run++;
      else if (prev_sclk) begin
        chk(hi_run == CLK_DIV, "R8 high phase", hi_run, CLK_DIV);
        hi_run = 0;
      end
      if (spi_sclk && !prev_sclk)
        chk(lo_run >= CLK_DIV, "R8 low phase", lo_run, CLK_DIV);
      if (spi_sclk || spi_cs_n) lo_run = 0;
      else if (!tx_req) lo_run++;
      if (!spi_cs_n && prev_cs)
        chk(cs_hi_run >= 4 * CLK_DIV, "R10 deselect gap", cs_hi_run, 4 * CLK_DIV);
      if (spi_cs_n) cs_hi_run++; else cs_hi_run = 0;
      chk(!(status_valid && rx_valid), "R4 pulses exclusive", {status_valid, rx_valid}, 0);
      if (status_valid) got_st.push_back(status);
      if (rx_valid) got_rx.push_back(rx_byte);
      if (done) done_cnt++;
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic run(input int kind, input int addr, input int wdata, input int len,
                     input int stall, input int seed, input string tag);
    logic [7:0] exp_mosi[$];
    logic [7:0] exp_st[$];
    logic [7:0] exp_rx[$];
    logic rd;
    logic [5:0] a;
    int nb;
    rd = (kind == 1 || kind == 4);
    a = (kind == 3) ? 6'h3E : (kind == 4) ? 6'h3F : addr[5:0];
    nb = (kind == 0 || kind == 1) ? 2 : (kind == 3 || kind == 4) ? len : 0;
    while (!req_ready) @(negedge clk);
    reply_q.delete();
    mosi_q.delete();
    got_st.delete();
    got_rx.delete();
    txq.delete();
    done_cnt = 0;
    stall_cyc = 0;
    stall_lim = stall;
    wait_n = 0;
    reply_q.push_back(8'(8'h40 + seed));
    exp_st.push_back(8'(8'h40 + seed));
    exp_mosi.push_back({1'b0, rd, a});
    for (int i = 0; i < nb; i++) begin
      logic [7:0] r, t;
      r = 8'(8'h81 + seed * 7 + i * 13);
      t = 8'(8'h10 + seed + i * 29);
      reply_q.push_back(r);
      case (kind)
        0: exp_mosi.push_back(i == 0 ? wdata[15:8] : wdata[7:0]);
        1, 4: begin exp_mosi.push_back(8'h00); exp_rx.push_back(r); end
        3: begin txq.push_back(t); exp_mosi.push_back(t); exp_st.push_back(r); end
        default: ;
      endcase
    end
    req_kind = kind[2:0];
    req_addr = addr[5:0];
    req_wdata = wdata[15:0];
    req_len = len[LEN_W-1:0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!(done_cnt > 0 && req_ready));
    chk(done_cnt == 1, {tag, " R10 single done"}, done_cnt, 1);
    chk(mosi_q.size() == exp_mosi.size(), {tag, " R7 byte count in session"},
        mosi_q.size(), exp_mosi.size());
    for (int i = 0; i < exp_mosi.size() && i < mosi_q.size(); i++)
      chk(mosi_q[i] == exp_mosi[i], i == 0 ? {tag, " R1 header"} : {tag, " sent byte"},
          mosi_q[i], exp_mosi[i]);
    chk(got_st.size() == exp_st.size(), {tag, " R4 status count"}, got_st.size(), exp_st.size());
    for (int i = 0; i < exp_st.size() && i < got_st.size(); i++)
      chk(got_st[i] == exp_st[i], {tag, " R4 status value"}, got_st[i], exp_st[i]);
    chk(got_rx.size() == exp_rx.size(), {tag, " R6 rx count"}, got_rx.size(), exp_rx.size());
    for (int i = 0; i < exp_rx.size() && i < got_rx.size(); i++)
      chk(got_rx[i] == exp_rx[i], {tag, " R6 rx value"}, got_rx[i], exp_rx[i]);
    if (stall > 0)
      chk(stall_cyc >= stall * len, {tag, " R9 stall observed"}, stall_cyc, stall * len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R11 cs after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R11 sclk after reset", spi_sclk, 0);
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    chk({done, tx_req, rx_valid, status_valid} == 4'b0, "R11 pulses idle",
        {done, tx_req, rx_valid, status_valid}, 0);
    mon_on = 1;
    run(0, 6'h18, 16'h1234, 0, 0, 1, "R2 cfg write");
    run(0, 6'h1C, 16'hA5C3, 0, 0, 2, "R2 cfg write b");
    run(1, 6'h11, 0, 0, 0, 3, "R6 reg read");
    run(2, 6'h03, 0, 0, 0, 4, "R3 strobe");
    run(2, 6'h00, 0, 0, 0, 5, "R3 nop strobe");
    run(6, 6'h08, 0, 9, 0, 6, "R3 odd kind");
    run(3, 6'h00, 0, 5, 0, 7, "R5 tx burst");
    run(3, 6'h00, 0, 3, 25, 8, "R9 stalled tx burst");
    run(4, 6'h00, 0, 4, 0, 9, "R6 rx burst");
    run(4, 6'h00, 0, 0, 0, 10, "R6 empty rx burst");
    run(3, 6'h00, 0, 1, 1, 11, "R5 single tx");
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule